// File: doc/BRIEF.md
# Handshake Clock Domain Crossing Bridge

This block carries one multi-bit word at a time from a source clock domain to an unrelated destination clock domain. The source side offers a word through a valid/ready pair. Once the word is accepted, it is parked in a holding register. A single request line then announces it to the far side. Only that request bit, and the acknowledge bit that answers it, cross between the domains. Each of them passes through a chain of flip-flops clocked in the receiving domain.

The word itself is never synchronized bit by bit. Separate bit synchronizers could settle some bits to the new value and others to the old one. Instead, the destination samples the bus only after the synchronized request shows a new event. By then the bus has been stable for at least two destination cycles. The destination reports each word with a one-cycle valid pulse.

A parameter picks the signalling style. The return-to-zero style uses four control phases per word. The toggle style uses one transition of each line per word.

Top module: `hs_cdc_bridge`

## Requirements
- R1: With TWO_PHASE=0, request rises together with the accepted word. Acknowledge rises only after request is seen high. Request falls only after acknowledge is seen high. The source accepts no new word until it has seen acknowledge low again. Because of this, one word keeps the source busy for at least 6 source cycles.
- R2: With TWO_PHASE=1, each accepted word flips request exactly once, and each delivered word flips acknowledge exactly once. Neither line returns to zero. The source busy time per word is shorter than with TWO_PHASE=0 under the same clocks.
- R3: `src_ready` is high whenever the source side is idle. It is low from the cycle after a word is accepted (`src_valid` and `src_ready` both high at a rising `src_clk` edge) until the handshake for that word has completed.
- R4: `src_valid` raised while `src_ready` is low is ignored. No word is taken and nothing extra is delivered.
- R5: `dst_valid` is high for exactly one `dst_clk` cycle per word. In that cycle `dst_data` carries the word. `dst_data` keeps that value until the next pulse.
- R6: Every accepted word is delivered exactly once, in the order it was accepted.
- R7: After reset, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0.
- R8: Changing `src_data` after a word has been accepted has no effect on the word delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain reset, active high, synchronous |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Word offered by the source |
| src_ready | output | 1 | Bridge can take a word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain reset, active high, synchronous |
| dst_valid | output | 1 | One-cycle pulse: a word has arrived |
| dst_data | output | DATA_W | Last word delivered |

## Verification
The bench builds two copies of the bridge with DATA_W=16 and SYNC_STAGES=2. One copy uses TWO_PHASE=0 and the other uses TWO_PHASE=1. This puts both signalling styles under the same unrelated clock pair, so their busy times per word can be compared directly. While each word is in flight, the bench keeps `src_valid` high with a corrupted `src_data`. This exercises the ignored-offer and data-hold behaviour in both styles.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

  typedef enum logic [1:0] {
    S_IDLE      = 2'd0,
    S_WAIT_ACK  = 2'd1,
    S_WAIT_DROP = 2'd2
  } snd_state_t;

  // Level the request takes when a new word is launched.
  function automatic logic launch_level(input logic two_phase, input logic req_now);
    return two_phase ? ~req_now : 1'b1;
  endfunction

  // Sender side: has the far side answered the current request?
  function automatic logic answer_seen(input logic two_phase, input logic req_now,
                                       input logic ack_synced);
    return two_phase ? (ack_synced == req_now) : ack_synced;
  endfunction

  // Receiver side: does the synchronized request announce a new word?
  function automatic logic new_word(input logic two_phase, input logic req_synced,
                                    input logic ack_now);
    return (req_synced != ack_now) && (two_phase || req_synced);
  endfunction

endpackage

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/hs_cdc_sender.sv
module hs_cdc_sender
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ack_sync,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out
);
  snd_state_t        state_q;
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              answered;

  assign in_ready = (state_q == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign answered = answer_seen(TWO_PHASE, req_q, ack_sync);
  assign req_out  = req_q;
  assign data_out = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      req_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          data_q  <= in_data;
          req_q   <= launch_level(TWO_PHASE, req_q);
          state_q <= S_WAIT_ACK;
        end
        S_WAIT_ACK: if (answered) begin
          if (TWO_PHASE) begin
            state_q <= S_IDLE;
          end else begin
            req_q   <= 1'b0;
            state_q <= S_WAIT_DROP;
          end
        end
        S_WAIT_DROP: if (!ack_sync) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R3: busy right after acceptance
  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R8: launched word held while in flight
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready)) |-> $stable(data_out));

  generate
    if (TWO_PHASE) begin : g_toggle_chk
      // R2: request flips only on an accepted word
      p_one_flip_per_word_r2: assert property (@(posedge clk) disable iff (rst)
        (req_out != $past(req_out)) |-> $past(accept));
    end else begin : g_rtz_chk
      // R1: request falls only after acknowledge was seen high
      p_req_fall_after_ack_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(req_out) |-> $past(ack_sync));
      // R1: request rises only when acknowledge is back low
      p_req_rise_ack_low_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(req_out) |-> $past(!ack_sync));
    end
  endgenerate
endmodule

// File: rtl/hs_cdc_receiver.sv
module hs_cdc_receiver
  import hs_cdc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit TWO_PHASE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack_out,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              ack_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              arrival;

  assign arrival   = new_word(TWO_PHASE, req_sync, ack_q);
  assign ack_out   = ack_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= arrival;
      if (arrival) data_q <= bus_data;
      if (req_sync != ack_q) ack_q <= req_sync;
    end
  end

  // R5: single-cycle arrival pulse
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5: delivered word held between pulses
  p_data_held_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  generate
    if (!TWO_PHASE) begin : g_rtz_chk
      // R1: acknowledge rises only while request is seen high
      p_ack_rise_req_high_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_out) |-> $past(req_sync));
    end
  endgenerate
endmodule

// File: rtl/hs_cdc_bridge.sv
module hs_cdc_bridge #(
  parameter int DATA_W      = 16,
  parameter bit TWO_PHASE   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_src;
  logic              req_dst;
  logic              ack_dst;
  logic              ack_src;
  logic [DATA_W-1:0] held_word;

  hs_cdc_sender #(.DATA_W(DATA_W), .TWO_PHASE(TWO_PHASE)) u_sender (
    .clk      (src_clk),
    .rst      (src_rst),
    .in_valid (src_valid),
    .in_data  (src_data),
    .in_ready (src_ready),
    .ack_sync (ack_src),
    .req_out  (req_src),
    .data_out (held_word)
  );

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst   (dst_rst),
    .d_in  (req_src),
    .d_out (req_dst)
  );

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst   (src_rst),
    .d_in  (ack_dst),
    .d_out (ack_src)
  );

  hs_cdc_receiver #(.DATA_W(DATA_W), .TWO_PHASE(TWO_PHASE)) u_receiver (
    .clk       (dst_clk),
    .rst       (dst_rst),
    .req_sync  (req_dst),
    .bus_data  (held_word),
    .ack_out   (ack_dst),
    .out_valid (dst_valid),
    .out_data  (dst_data)
  );
endmodule

// File: tb/hs_cdc_bridge_bench.sv
`timescale 1ns/1ps
module hs_cdc_bridge_bench;
  localparam int W = 16;
  localparam int N = 10;
  localparam logic [W-1:0] WORDS [N] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0001,
                                         16'h8000, 16'h1234, 16'hFEDC, 16'h00FF, 16'hFF00};
  localparam int GAPS [N] = '{0, 3, 0, 1, 5, 0, 2, 0, 0, 4};

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst = 1'b1;
  logic dst_rst = 1'b1;
  always #5    src_clk = ~src_clk;
  always #6.85 dst_clk = ~dst_clk;

  logic         s_valid [2];
  logic [W-1:0] s_data  [2];
  logic         s_ready [2];
  logic         o_valid [2];
  logic [W-1:0] o_data  [2];

  hs_cdc_bridge #(.DATA_W(W), .TWO_PHASE(1'b0), .SYNC_STAGES(2)) u_hs_cdc_bridge (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(s_valid[0]), .src_data(s_data[0]),
    .src_ready(s_ready[0]), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_valid(o_valid[0]), .dst_data(o_data[0]));

  hs_cdc_bridge #(.DATA_W(W), .TWO_PHASE(1'b1), .SYNC_STAGES(2)) u_hs_cdc_bridge_tp (
    .src_clk(src_clk), .src_rst(src_rst), .src_valid(s_valid[1]), .src_data(s_data[1]),
    .src_ready(s_ready[1]), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .dst_valid(o_valid[1]), .dst_data(o_data[1]));

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q [2][32];
  int wr_i [2];
  int rd_i [2];
  logic prev_v [2];
  int busy_first [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard on the destination side: R5 single pulse, R6 order and uniqueness
  always @(negedge dst_clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!dst_rst && o_valid[m]) begin
        chk(!prev_v[m], "R5 pulse width", 32'(prev_v[m]), 32'd0);
        if (rd_i[m] < wr_i[m]) begin
          chk(o_data[m] == exp_q[m][rd_i[m]], "R6 word order", 32'(o_data[m]),
              32'(exp_q[m][rd_i[m]]));
        end else begin
          chk(1'b0, "R6 extra word", 32'(rd_i[m]), 32'(wr_i[m]));
        end
        rd_i[m]++;
      end
      prev_v[m] = o_valid[m];
    end
  end

  task automatic send_word(input int m, input logic [W-1:0] w, output int busy);
    @(negedge src_clk);
    while (!s_ready[m]) @(negedge src_clk);
    s_valid[m] = 1'b1;
    s_data[m]  = w;
    exp_q[m][wr_i[m]] = w;
    wr_i[m]++;
    @(negedge src_clk);
    chk(s_ready[m] == 1'b0, "R3 busy after accept", 32'(s_ready[m]), 32'd0);
    // R4/R8: keep offering a corrupted word while busy
    s_data[m] = ~w;
    busy = 1;
    while (!s_ready[m]) begin
      @(negedge src_clk);
      busy++;
    end
    s_valid[m] = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int b;
    for (int m = 0; m < 2; m++) begin
      s_valid[m] = 1'b0;
      s_data[m]  = '0;
      wr_i[m] = 0;
      rd_i[m] = 0;
      prev_v[m] = 1'b0;
      busy_first[m] = 0;
    end
    repeat (4) @(negedge src_clk);
    src_rst = 1'b0;
    repeat (2) @(negedge dst_clk);
    dst_rst = 1'b0;
    @(negedge src_clk);
    // R7 reset state
    for (int m = 0; m < 2; m++) begin
      chk(s_ready[m] == 1'b1, "R7 ready after reset", 32'(s_ready[m]), 32'd1);
      chk(o_valid[m] == 1'b0, "R7 valid after reset", 32'(o_valid[m]), 32'd0);
      chk(o_data[m] == '0, "R7 data after reset", 32'(o_data[m]), 32'd0);
    end

    // Vector table walk, both signalling styles
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < N; i++) begin
        repeat (GAPS[i]) @(negedge src_clk);
        send_word(m, WORDS[i], b);
        if (i == 0) busy_first[m] = b;
      end
      repeat (40) @(negedge src_clk);
      chk(rd_i[m] == N, "R4 R6 delivered count", 32'(rd_i[m]), 32'(N));
      chk(o_data[m] == WORDS[N-1], "R5 R8 last word held", 32'(o_data[m]), 32'(WORDS[N-1]));
    end

    chk(busy_first[0] >= 6, "R1 four-phase busy cycles", 32'(busy_first[0]), 32'd6);
    chk(busy_first[1] < busy_first[0], "R2 toggle faster",
        32'(busy_first[1]), 32'(busy_first[0]));

    // Back-to-back words with no gap, toggle style
    for (int i = 0; i < 4; i++) begin
      send_word(1, WORDS[i] ^ 16'h0F0F, b);
    end
    repeat (40) @(negedge src_clk);
    chk(rd_i[1] == N + 4, "R2 R6 back-to-back count", 32'(rd_i[1]), 32'(N + 4));
    for (int m = 0; m < 2; m++) begin
      chk(s_ready[m] == 1'b1, "R3 idle ready", 32'(s_ready[m]), 32'd1);
    end

    // Reset in the middle of nothing: state returns to the reset values
    src_rst = 1'b1;
    dst_rst = 1'b1;
    repeat (3) @(negedge dst_clk);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    @(negedge src_clk);
    @(negedge dst_clk);
    chk(o_data[0] == '0, "R7 data after second reset", 32'(o_data[0]), 32'd0);
    chk(s_ready[0] == 1'b1, "R7 ready after second reset", 32'(s_ready[0]), 32'd1);
    finish_run();
  end
endmodule